// File: doc/BRIEF.md
# EPC Length Configuration Controller

This block holds the capacity-split setting that decides how a fixed pool of tag memory words is divided between the electronic product code (EPC) and the user area. In the short setting the EPC uses 8 words and 9 words are left over for the user bank. In the long setting the EPC grows to 17 words, taking those same 9 words, and the user bank has no usable words.

Software changes the split by writing a code word to one fixed address in the EPC bank. Writing 0001h selects the long EPC. Writing 0000h returns to the short EPC. A permanent-lock status input for the EPC bank freezes the choice. The block drives the current mode and the effective EPC length, answers reads of the code word, and translates user-bank word addresses to physical shared-pool addresses. It refuses any user-bank access that falls outside what the current split allows.

All outputs are registered. A request that is presented in one cycle is answered on the following clock edge, and the mode changes on that same edge.

Top module: `epc_len_ctrl`

## Requirements
- R1: During and after a synchronous reset, `long_epc` is 0, `epc_len_words` is 8, `rsp_valid` is 0 and `user_map_valid` is 0.
- R2: A write (`req_write`=1) of 0001h to the EPC bank (`req_bank`=2'b01) at word 14h, with `epc_locked`=0, sets `long_epc` to 1 and `epc_len_words` to 17 on the next edge, and the response carries `rsp_error`=0.
- R3: A write of 0000h to that word, with `epc_locked`=0, sets `long_epc` to 0 and `epc_len_words` to 8 on the next edge, with `rsp_error`=0. The mode may be toggled any number of times.
- R4: A write of any value other than 0000h or 0001h to that word leaves the mode unchanged and answers with `rsp_error`=1.
- R5: While `epc_locked`=1, a write to the code word never changes the mode and answers with `rsp_error`=1, whatever the data.
- R6: A read of EPC-bank word 14h answers with `rsp_rdata` equal to 0000h in the short mode or 0001h in the long mode, and `rsp_error`=0.
- R7: In the long mode, every user-bank access (`req_bank`=2'b11), whether read or write, answers with `rsp_error`=1 and `user_map_valid`=0.
- R8: In the short mode, user-bank words 0 to 8 answer with `rsp_error`=0, `user_map_valid`=1 and `user_map_addr` = 24 + word. Words 9 and above answer with `rsp_error`=1 and `user_map_valid`=0.
- R9: `rsp_valid` is 1 exactly in the cycle after a cycle with `req_valid`=1. Accesses to other words or banks (reserved 2'b00, TID 2'b10) answer with `rsp_error`=0 and `rsp_rdata`=0, and leave the mode unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bank | input | 2 | Bank: 00 reserved, 01 EPC, 10 TID, 11 user |
| req_addr | input | 8 | Word address within the bank |
| req_wdata | input | 16 | Write data |
| epc_locked | input | 1 | EPC bank permanently locked |
| long_epc | output | 1 | 1 = long EPC mode |
| epc_len_words | output | 5 | Effective EPC length in words (8 or 17) |
| rsp_valid | output | 1 | Response valid |
| rsp_error | output | 1 | Request refused |
| rsp_rdata | output | 16 | Read data for the code word |
| user_map_valid | output | 1 | User access granted |
| user_map_addr | output | 6 | Physical shared-pool word address |

## Verification
Two things can meet in the same cycle: a write to the code word and a change of the lock status, which the write must obey as sampled in that cycle. The bench forces this by driving `epc_locked` high in exactly the cycle of a mode-changing write, and also drops it in the cycle of a write. It then checks the mode and the error flag on the next edge. A second meeting point is a user-bank access issued right after a mode switch. That access must be judged against the new split, and directed sequences check it. Random traffic then mixes lock changes, good and bad code values, and user words near the boundary at word 9.

// File: rtl/epc_len_pkg.sv
package epc_len_pkg;
  typedef enum logic [1:0] {
    BANK_RSV  = 2'b00,
    BANK_EPC  = 2'b01,
    BANK_TID  = 2'b10,
    BANK_USER = 2'b11
  } bank_e;

  typedef enum logic [0:0] {
    MODE_SHORT = 1'b0,
    MODE_LONG  = 1'b1
  } mode_e;
endpackage

// File: rtl/epc_len_mode_reg.sv
module epc_len_mode_reg
  import epc_len_pkg::*;
#(
  parameter int SHORT_WORDS = 8,
  parameter int LONG_WORDS  = 17,
  parameter int LEN_W       = $clog2(LONG_WORDS + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             go_long,
  input  logic             go_short,
  output mode_e            mode_q,
  output logic [LEN_W-1:0] len_q
);
  localparam logic [LEN_W-1:0] SHORT_LEN = LEN_W'(SHORT_WORDS);
  localparam logic [LEN_W-1:0] LONG_LEN  = LEN_W'(LONG_WORDS);

  // the mode and the length are kept as separate flops so the length can be used directly by consumers
  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= MODE_SHORT;
      len_q  <= SHORT_LEN;
    end else if (go_long) begin
      mode_q <= MODE_LONG;
      len_q  <= LONG_LEN;
    end else if (go_short) begin
      mode_q <= MODE_SHORT;
      len_q  <= SHORT_LEN;
    end
  end
endmodule

// File: rtl/epc_len_user_map.sv
module epc_len_user_map
  import epc_len_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int FREE_WORDS  = 9,
  parameter int SHARED_BASE = 24,
  parameter int PHYS_W      = 6
) (
  input  logic              user_hit,
  input  mode_e             mode,
  input  logic [ADDR_W-1:0] word,
  output logic              grant,
  output logic              deny,
  output logic [PHYS_W-1:0] phys
);
  localparam logic [ADDR_W-1:0] FREE_LIM = ADDR_W'(FREE_WORDS);
  localparam logic [PHYS_W-1:0] BASE     = PHYS_W'(SHARED_BASE);

  logic in_range;

  generate
    if (FREE_WORDS == 0) begin : g_no_free
      assign in_range = 1'b0;
    end else begin : g_free
      assign in_range = (word < FREE_LIM);
    end
  endgenerate

  always_comb begin
    grant = user_hit && (mode == MODE_SHORT) && in_range;
    deny  = user_hit && !grant;
    phys  = BASE + PHYS_W'(word);
  end
endmodule

// File: rtl/epc_len_decode.sv
module epc_len_decode
  import epc_len_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 16,
  parameter int CFG_ADDR = 'h14
) (
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [1:0]        req_bank,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              locked,
  input  mode_e             mode,
  output logic              go_long,
  output logic              go_short,
  output logic              cfg_err,
  output logic              user_hit,
  output logic [DATA_W-1:0] rdata
);
  localparam logic [ADDR_W-1:0] CFG_WORD  = ADDR_W'(CFG_ADDR);
  localparam logic [DATA_W-1:0] CODE_LONG = DATA_W'(1);
  localparam logic [DATA_W-1:0] CODE_SHRT = '0;

  logic cfg_hit, cfg_wr, code_ok, accept;

  always_comb begin
    cfg_hit  = req_valid && (bank_e'(req_bank) == BANK_EPC) && (req_addr == CFG_WORD);
    cfg_wr   = cfg_hit && req_write;
    code_ok  = (req_wdata == CODE_LONG) || (req_wdata == CODE_SHRT);
    accept   = cfg_wr && !locked && code_ok;
    go_long  = accept && (req_wdata == CODE_LONG);
    go_short = accept && (req_wdata == CODE_SHRT);
    cfg_err  = cfg_wr && !accept;
    user_hit = req_valid && (bank_e'(req_bank) == BANK_USER);
    rdata    = (cfg_hit && !req_write) ? DATA_W'(mode) : '0;
  end
endmodule

// File: rtl/epc_len_ctrl.sv
module epc_len_ctrl
  import epc_len_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 16,
  parameter int CFG_ADDR    = 'h14,
  parameter int SHORT_WORDS = 8,
  parameter int LONG_WORDS  = 17,
  parameter int SHARED_BASE = 24,
  parameter int PHYS_W      = 6,
  parameter int LEN_W       = $clog2(LONG_WORDS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [1:0]        req_bank,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              epc_locked,
  output logic              long_epc,
  output logic [LEN_W-1:0]  epc_len_words,
  output logic              rsp_valid,
  output logic              rsp_error,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              user_map_valid,
  output logic [PHYS_W-1:0] user_map_addr
);
  localparam int FREE_WORDS = LONG_WORDS - SHORT_WORDS;

  mode_e             mode_q;
  logic              go_long, go_short, cfg_err, user_hit;
  logic              grant, deny;
  logic [DATA_W-1:0] rd_next;
  logic [PHYS_W-1:0] phys_next;

  epc_len_decode #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CFG_ADDR(CFG_ADDR)
  ) u_decode (
    .req_valid(req_valid), .req_write(req_write), .req_bank(req_bank),
    .req_addr(req_addr), .req_wdata(req_wdata), .locked(epc_locked),
    .mode(mode_q), .go_long(go_long), .go_short(go_short),
    .cfg_err(cfg_err), .user_hit(user_hit), .rdata(rd_next)
  );

  epc_len_mode_reg #(
    .SHORT_WORDS(SHORT_WORDS), .LONG_WORDS(LONG_WORDS), .LEN_W(LEN_W)
  ) u_mode (
    .clk(clk), .rst(rst), .go_long(go_long), .go_short(go_short),
    .mode_q(mode_q), .len_q(epc_len_words)
  );

  epc_len_user_map #(
    .ADDR_W(ADDR_W), .FREE_WORDS(FREE_WORDS),
    .SHARED_BASE(SHARED_BASE), .PHYS_W(PHYS_W)
  ) u_map (
    .user_hit(user_hit), .mode(mode_q), .word(req_addr),
    .grant(grant), .deny(deny), .phys(phys_next)
  );

  assign long_epc = (mode_q == MODE_LONG);

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid      <= 1'b0;
      rsp_error      <= 1'b0;
      rsp_rdata      <= '0;
      user_map_valid <= 1'b0;
      user_map_addr  <= '0;
    end else begin
      rsp_valid      <= req_valid;
      rsp_error      <= cfg_err || deny;
      rsp_rdata      <= rd_next;
      user_map_valid <= grant;
      user_map_addr  <= grant ? phys_next : '0;
    end
  end
endmodule

// File: rtl/epc_len_ctrl_chk.sv
module epc_len_ctrl_chk #(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 16,
  parameter int CFG_ADDR    = 'h14,
  parameter int SHORT_WORDS = 8,
  parameter int LONG_WORDS  = 17,
  parameter int LEN_W       = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_write,
  input logic [1:0]        req_bank,
  input logic [ADDR_W-1:0] req_addr,
  input logic [DATA_W-1:0] req_wdata,
  input logic              epc_locked,
  input logic              long_epc,
  input logic [LEN_W-1:0]  epc_len_words,
  input logic              rsp_valid,
  input logic              rsp_error,
  input logic              user_map_valid
);
  logic cfg_wr;
  assign cfg_wr = req_valid && req_write && req_bank == 2'b01 &&
                  req_addr == ADDR_W'(CFG_ADDR);

  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (!long_epc && epc_len_words == LEN_W'(SHORT_WORDS) && !rsp_valid));

  assert_go_long_R2: assert property (@(posedge clk) disable iff (rst)
    (cfg_wr && !epc_locked && req_wdata == DATA_W'(1)) |=> (long_epc && !rsp_error));

  assert_len_tracks_mode_R2: assert property (@(posedge clk) disable iff (rst)
    epc_len_words == (long_epc ? LEN_W'(LONG_WORDS) : LEN_W'(SHORT_WORDS)));

  assert_go_short_R3: assert property (@(posedge clk) disable iff (rst)
    (cfg_wr && !epc_locked && req_wdata == '0) |=> (!long_epc && !rsp_error));

  assert_bad_code_R4: assert property (@(posedge clk) disable iff (rst)
    (cfg_wr && req_wdata > DATA_W'(1)) |=> ($stable(long_epc) && rsp_error));

  assert_locked_frozen_R5: assert property (@(posedge clk) disable iff (rst)
    epc_locked |=> $stable(long_epc));

  assert_user_denied_R7: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_bank == 2'b11 && long_epc) |=> (rsp_error && !user_map_valid));

  assert_rsp_follows_R9: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);

  assert_no_idle_rsp_R9: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);
endmodule

bind epc_len_ctrl epc_len_ctrl_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CFG_ADDR(CFG_ADDR),
  .SHORT_WORDS(SHORT_WORDS), .LONG_WORDS(LONG_WORDS), .LEN_W(LEN_W)
) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
  .req_bank(req_bank), .req_addr(req_addr), .req_wdata(req_wdata),
  .epc_locked(epc_locked), .long_epc(long_epc), .epc_len_words(epc_len_words),
  .rsp_valid(rsp_valid), .rsp_error(rsp_error), .user_map_valid(user_map_valid)
);

// File: tb/test_epc_len_ctrl.sv
module test_epc_len_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid, req_write, epc_locked;
  logic [1:0]  req_bank;
  logic [7:0]  req_addr;
  logic [15:0] req_wdata;
  logic        long_epc;
  logic [4:0]  epc_len_words;
  logic        rsp_valid, rsp_error, user_map_valid;
  logic [15:0] rsp_rdata;
  logic [5:0]  user_map_addr;

  int checks = 0;
  int errors = 0;
  bit model_long = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  epc_len_ctrl i_epc_len_ctrl (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_bank(req_bank), .req_addr(req_addr), .req_wdata(req_wdata),
    .epc_locked(epc_locked), .long_epc(long_epc), .epc_len_words(epc_len_words),
    .rsp_valid(rsp_valid), .rsp_error(rsp_error), .rsp_rdata(rsp_rdata),
    .user_map_valid(user_map_valid), .user_map_addr(user_map_addr)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic bit is_cfg(input logic [1:0] b, input logic [7:0] a);
    return b == 2'b01 && a == 8'h14;
  endfunction

  function automatic bit exp_error(input bit wr, input logic [1:0] b,
                                   input logic [7:0] a, input logic [15:0] d,
                                   input bit lk, input bit lng);
    if (is_cfg(b, a) && wr) return lk || d > 16'd1;
    if (b == 2'b11) return lng || a > 8'd8;
    return 1'b0;
  endfunction

  function automatic bit exp_next_mode(input bit wr, input logic [1:0] b,
                                       input logic [7:0] a, input logic [15:0] d,
                                       input bit lk, input bit lng);
    if (is_cfg(b, a) && wr && !lk && d <= 16'd1) return d[0];
    return lng;
  endfunction

  task automatic access(input bit wr, input logic [1:0] b, input logic [7:0] a,
                        input logic [15:0] d, input bit lk, input string tag);
    bit e_err, e_mode, e_map;
    int e_rd;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_bank = b;
    req_addr = a; req_wdata = d; epc_locked = lk;
    e_err  = exp_error(wr, b, a, d, lk, model_long);
    e_mode = exp_next_mode(wr, b, a, d, lk, model_long);
    e_map  = (b == 2'b11) && !model_long && a <= 8'd8;
    e_rd   = (is_cfg(b, a) && !wr) ? int'(model_long) : 0;
    @(posedge clk); #1;
    req_valid = 1'b0;
    model_long = e_mode;
    check({tag, " rsp_valid R9"}, int'(rsp_valid), 1);
    check({tag, " rsp_error"}, int'(rsp_error), int'(e_err));
    check({tag, " mode"}, int'(long_epc), int'(e_mode));
    check({tag, " len R2"}, int'(epc_len_words), e_mode ? 17 : 8);
    check({tag, " rdata R6"}, int'(rsp_rdata), e_rd);
    check({tag, " map_valid R8"}, int'(user_map_valid), int'(e_map));
    if (e_map) check({tag, " map_addr R8"}, int'(user_map_addr), 24 + int'(a));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int unsigned seed_v;
    seed_v = $urandom(32'h5eed_0a17);
    rst = 1'b1; req_valid = 1'b0; req_write = 1'b0; req_bank = 2'b00;
    req_addr = '0; req_wdata = '0; epc_locked = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset long_epc", int'(long_epc), 0);
    check("R1 reset len", int'(epc_len_words), 8);
    check("R1 reset rsp_valid", int'(rsp_valid), 0);
    check("R1 reset map_valid", int'(user_map_valid), 0);
    @(negedge clk); rst = 1'b0;

    @(posedge clk); #1;
    check("R9 idle no rsp", int'(rsp_valid), 0);

    access(1'b0, 2'b01, 8'h14, 16'h0, 1'b0, "R6 read short");
    access(1'b0, 2'b11, 8'd0,  16'h0, 1'b0, "R8 user w0");
    access(1'b1, 2'b11, 8'd8,  16'h0, 1'b0, "R8 user w8");
    access(1'b0, 2'b11, 8'd9,  16'h0, 1'b0, "R8 user w9 over");
    access(1'b1, 2'b01, 8'h14, 16'h0002, 1'b0, "R4 bad code");
    access(1'b1, 2'b01, 8'h14, 16'h8001, 1'b0, "R4 bad high code");
    access(1'b1, 2'b01, 8'h14, 16'h0001, 1'b0, "R2 go long");
    access(1'b0, 2'b11, 8'd0,  16'h0, 1'b0, "R7 user read after switch");
    access(1'b1, 2'b11, 8'd3,  16'h0, 1'b0, "R7 user write long");
    access(1'b0, 2'b01, 8'h14, 16'h0, 1'b0, "R6 read long");
    access(1'b1, 2'b01, 8'h14, 16'h0000, 1'b1, "R5 lock same cycle");
    access(1'b1, 2'b01, 8'h14, 16'h0005, 1'b1, "R5 lock bad code");
    access(1'b1, 2'b01, 8'h14, 16'h0000, 1'b0, "R3 go short");
    access(1'b1, 2'b01, 8'h14, 16'h0001, 1'b0, "R3 toggle long");
    access(1'b1, 2'b01, 8'h14, 16'h0000, 1'b0, "R3 toggle short");
    access(1'b1, 2'b01, 8'h14, 16'h0001, 1'b1, "R5 locked go long");
    access(1'b1, 2'b00, 8'h14, 16'h0001, 1'b0, "R9 reserved bank");
    access(1'b1, 2'b01, 8'h15, 16'h0001, 1'b0, "R9 other epc word");
    access(1'b0, 2'b10, 8'h14, 16'h0001, 1'b0, "R9 tid bank");

    for (int i = 0; i < 600; i++) begin
      logic [1:0]  b;
      logic [7:0]  a;
      logic [15:0] d;
      bit wr, lk;
      b  = 2'($urandom_range(0, 3));
      wr = 1'($urandom_range(0, 1));
      lk = ($urandom_range(0, 9) == 0);
      case ($urandom_range(0, 3))
        0, 1: begin b = 2'b01; a = 8'h14; end
        2:    a = 8'($urandom_range(0, 12));
        default: a = 8'($urandom_range(0, 255));
      endcase
      d = ($urandom_range(0, 4) == 0) ? 16'($urandom_range(0, 65535))
                                      : 16'($urandom_range(0, 1));
      access(wr, b, a, d, lk, "random");
    end

    @(negedge clk);
    @(posedge clk); #1;
    check("R9 no rsp after idle", int'(rsp_valid), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule